// File: doc/BRIEF.md
# Checkpointed Watchdog Supervisor

This block is a retriggerable watchdog that pulls a system reset line when software stops servicing it within a programmable window. Software does not service it with a bare "kick". Each section of the main loop first marks its own checkpoint flag. A kick restarts the countdown only when every required checkpoint has been marked. If any required checkpoint is still clear, the kick is refused and the countdown keeps running toward a reset. The first refused kick also records which checkpoints were missing. Software can read that record after the restart to find the stalled section.

Software drives the block through a small write port. Address 0 marks checkpoints, address 1 kicks, address 2 selects which checkpoints are required, and address 3 clears the recorded status. The flags, the mask, the recorded cause, and a sticky "restart came from the watchdog" bit are visible on output ports at all times. A debug-halt input freezes the watchdog so that a stopped debugger session does not cause a restart. The timeout and the reset pulse width are counted in clock cycles and set by parameters. The default timeout is 6,250,000 cycles, which is 50 ms at 125 MHz. That comfortably exceeds a main loop that takes 35 ms in the worst case.

Top module: `wdog_supervisor`

## Requirements
- R1: While `rst_n` is low and just after it is released, `sys_rst_o` is 0, all checkpoint flags are 0, the required mask is all ones, the cause is 0 with `fail_valid_o` 0, and `wdt_fired_o` is 0. The countdown starts from the full interval.
- R2: A write to address 0 ORs `wr_data_i[NUM_CKPT-1:0]` into the checkpoint flags. Data bits above that range are ignored. Outside the end of a reset pulse, flags only drop when a kick is accepted.
- R3: A write to address 1 (data ignored) is accepted when `(flags & mask) == mask`. An accepted kick clears all flags and restarts the countdown. `sys_rst_o` then rises exactly `TIMEOUT_CYCLES` clock edges after the kick's edge unless another kick is accepted.
- R4: A kick that does not meet the mask is refused. The flags stay as they were, and the countdown is not reloaded, so the reset arrives when the earlier schedule says.
- R5: The first refused kick loads `fail_cause_o` with `mask & ~flags` and sets `fail_valid_o`. Later refusals leave the cause unchanged. Writing address 3 with data bit 0 set clears the cause and `fail_valid_o`.
- R6: On expiry, `sys_rst_o` is high for exactly `RST_PULSE_CYCLES` consecutive cycles.
- R7: At the end of the pulse, the flags clear, the countdown reloads to the full interval, and `wdt_fired_o` is set. The recorded cause survives the pulse. Writing address 3 with data bit 1 set clears `wdt_fired_o`.
- R8: While `dbg_halt_i` is high, no reset pulse starts, the countdown is held at the full interval, and kicks are ignored. After release, `sys_rst_o` rises `TIMEOUT_CYCLES` edges after the last edge at which debug was high.
- R9: A write to address 2 loads the required mask from `wr_data_i[NUM_CKPT-1:0]`. Flags outside the mask are not needed for a kick, and a zero mask accepts every kick.
- R10: All writes are ignored while `sys_rst_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 checkpoint, 1 kick, 2 mask, 3 clear |
| wr_data_i | input | 8 | Write data |
| dbg_halt_i | input | 1 | Debug halt: freezes the watchdog |
| sys_rst_o | output | 1 | System reset pulse |
| ckpt_flags_o | output | NUM_CKPT | Current checkpoint flags |
| req_mask_o | output | NUM_CKPT | Required checkpoint mask |
| fail_cause_o | output | NUM_CKPT | Missing flags at the first refused kick |
| fail_valid_o | output | 1 | Cause register holds a capture |
| wdt_fired_o | output | 1 | Sticky: a watchdog reset pulse completed |

## Verification
The bench runs with three checkpoints and sweeps every mask against every flag pattern for a single kick. A design that compares the wrong operand would accept kicks with missing flags or refuse good ones. A design that forms the cause with the wrong polarity would record the wrong bits. The timing tests count edges from an accepted kick, from a refused kick, and from debug release to the rising edge of the reset pulse, and they also count the pulse width. An off-by-one counter, a refused kick that reloads anyway, or a debug release that resumes a partly used count would each move that edge. Further tests check three things: that a second refusal overwrites no earlier cause, that the cause survives the pulse, and that mask writes issued during the pulse are dropped.

// File: rtl/wdog_pkg.sv
// Package: shared register addresses and phase encoding for the watchdog
// supervisor. Assumes a two-bit write address and an eight-bit write data bus.
package wdog_pkg;
    localparam int WR_DATA_W = 8;
    localparam int MAX_CKPT  = 8;

    typedef enum logic [1:0] {
        REG_CKPT  = 2'd0,
        REG_KICK  = 2'd1,
        REG_MASK  = 2'd2,
        REG_CLEAR = 2'd3
    } wdog_reg_e;

    typedef enum logic {
        PH_COUNT = 1'b0,
        PH_PULSE = 1'b1
    } wdog_phase_e;
endpackage

// File: rtl/wdog_ckpt_bank.sv
// Module: checkpoint flag bank with its required-mask register.
// Evaluates whether a kick would be accepted and which required flags are
// missing. Assumes the caller already gates strobes by debug and pulse state.
module wdog_ckpt_bank #(
    parameter int NUM_CKPT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_en,
    input  logic [NUM_CKPT-1:0] set_bits,
    input  logic                mask_wr,
    input  logic [NUM_CKPT-1:0] mask_bits,
    input  logic                clear_all,
    output logic [NUM_CKPT-1:0] flags,
    output logic [NUM_CKPT-1:0] mask,
    output logic                all_met,
    output logic [NUM_CKPT-1:0] missing
);
    localparam logic [NUM_CKPT-1:0] MASK_RESET = {NUM_CKPT{1'b1}};

    logic [NUM_CKPT-1:0] flag_q;
    logic [NUM_CKPT-1:0] mask_q;

    // Flag storage: one flop per checkpoint, set by writes, cleared together.
    for (genvar g = 0; g < NUM_CKPT; g++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_q[g] <= 1'b0;
            else if (clear_all)
                flag_q[g] <= 1'b0;
            else if (set_en && set_bits[g])
                flag_q[g] <= 1'b1;
        end
    end

    // Mask register: selects which checkpoints a kick requires.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_q <= MASK_RESET;
        else if (mask_wr)
            mask_q <= mask_bits;
    end

    // Kick evaluation: required flags not yet marked.
    always_comb begin
        missing = mask_q & ~flag_q;
        all_met = (missing == '0);
    end

    assign flags = flag_q;
    assign mask  = mask_q;
endmodule

// File: rtl/wdog_timer.sv
// Module: retriggerable countdown with a fixed-width reset pulse.
// The count is held at the full interval while hold is high. Reload wins over
// expiry in the same cycle. Assumes TIMEOUT_CYCLES >= 2 and RST_PULSE_CYCLES >= 1.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int TIMEOUT_CYCLES   = 6_250_000,
    parameter int RST_PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    input  logic reload,
    output logic pulse_active,
    output logic pulse_done
);
    localparam int CNT_W = $clog2(TIMEOUT_CYCLES);
    localparam int PUL_W = $clog2(RST_PULSE_CYCLES) + 1;
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TIMEOUT_CYCLES - 1);
    localparam logic [PUL_W-1:0] PUL_FULL = PUL_W'(RST_PULSE_CYCLES - 1);

    wdog_phase_e     phase_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PUL_W-1:0] pcnt_q;

    // Phase sequencer: count down, fire the pulse, then return to counting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_COUNT;
            cnt_q   <= CNT_FULL;
            pcnt_q  <= '0;
        end else begin
            case (phase_q)
                PH_COUNT: begin
                    if (hold || reload)
                        cnt_q <= CNT_FULL;
                    else if (cnt_q == '0) begin
                        phase_q <= PH_PULSE;
                        pcnt_q  <= PUL_FULL;
                    end else
                        cnt_q <= cnt_q - 1'b1;
                end
                PH_PULSE: begin
                    if (pcnt_q == '0) begin
                        phase_q <= PH_COUNT;
                        cnt_q   <= CNT_FULL;
                    end else
                        pcnt_q <= pcnt_q - 1'b1;
                end
                default: phase_q <= PH_COUNT;
            endcase
        end
    end

    // Pulse status toward the rest of the block.
    always_comb begin
        pulse_active = (phase_q == PH_PULSE);
        pulse_done   = (phase_q == PH_PULSE) && (pcnt_q == '0);
    end
endmodule

// File: rtl/wdog_cause_log.sv
// Module: failure-cause capture and sticky watchdog-fired status.
// Captures only the first refusal until software clears it. Assumes the
// capture and clear strobes never coincide (they come from different addresses).
module wdog_cause_log #(
    parameter int NUM_CKPT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                capture,
    input  logic [NUM_CKPT-1:0] capture_bits,
    input  logic                clr_cause,
    input  logic                clr_fired,
    input  logic                set_fired,
    output logic [NUM_CKPT-1:0] cause,
    output logic                cause_valid,
    output logic                fired
);
    // Cause register: loads on the first refused kick only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cause       <= '0;
            cause_valid <= 1'b0;
        end else if (clr_cause) begin
            cause       <= '0;
            cause_valid <= 1'b0;
        end else if (capture && !cause_valid) begin
            cause       <= capture_bits;
            cause_valid <= 1'b1;
        end
    end

    // Sticky fired bit: set at pulse end, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fired <= 1'b0;
        else if (set_fired)
            fired <= 1'b1;
        else if (clr_fired)
            fired <= 1'b0;
    end
endmodule

// File: rtl/wdog_supervisor.sv
// Module: top of the checkpointed watchdog supervisor.
// Decodes the write port, gates kicks by debug and pulse state, and ties the
// flag bank, timer and cause log together. Assumes 1 <= NUM_CKPT <= 8 and
// synchronous active-low reset.
module wdog_supervisor
    import wdog_pkg::*;
#(
    parameter int NUM_CKPT         = 4,
    parameter int TIMEOUT_CYCLES   = 6_250_000,
    parameter int RST_PULSE_CYCLES = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en_i,
    input  logic [1:0]           wr_addr_i,
    input  logic [WR_DATA_W-1:0] wr_data_i,
    input  logic                 dbg_halt_i,
    output logic                 sys_rst_o,
    output logic [NUM_CKPT-1:0]  ckpt_flags_o,
    output logic [NUM_CKPT-1:0]  req_mask_o,
    output logic [NUM_CKPT-1:0]  fail_cause_o,
    output logic                 fail_valid_o,
    output logic                 wdt_fired_o
);
    wdog_reg_e           addr;
    logic                wr_ok;
    logic                kick_req, kick_good, kick_bad;
    logic                pulse_active, pulse_done;
    logic                all_met;
    logic [NUM_CKPT-1:0] missing;
    logic [NUM_CKPT-1:0] data_ckpt;

    // Write decode: writes are dropped while the reset pulse is active.
    always_comb begin
        addr      = wdog_reg_e'(wr_addr_i);
        data_ckpt = wr_data_i[NUM_CKPT-1:0];
        wr_ok     = wr_en_i && !pulse_active;
        kick_req  = wr_ok && (addr == REG_KICK) && !dbg_halt_i;
        kick_good = kick_req && all_met;
        kick_bad  = kick_req && !all_met;
    end

    wdog_ckpt_bank #(.NUM_CKPT(NUM_CKPT)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_en    (wr_ok && (addr == REG_CKPT)),
        .set_bits  (data_ckpt),
        .mask_wr   (wr_ok && (addr == REG_MASK)),
        .mask_bits (data_ckpt),
        .clear_all (kick_good || pulse_done),
        .flags     (ckpt_flags_o),
        .mask      (req_mask_o),
        .all_met   (all_met),
        .missing   (missing)
    );

    wdog_timer #(
        .TIMEOUT_CYCLES   (TIMEOUT_CYCLES),
        .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .hold         (dbg_halt_i),
        .reload       (kick_good),
        .pulse_active (pulse_active),
        .pulse_done   (pulse_done)
    );

    wdog_cause_log #(.NUM_CKPT(NUM_CKPT)) u_log (
        .clk          (clk),
        .rst_n        (rst_n),
        .capture      (kick_bad),
        .capture_bits (missing),
        .clr_cause    (wr_ok && (addr == REG_CLEAR) && wr_data_i[0]),
        .clr_fired    (wr_ok && (addr == REG_CLEAR) && wr_data_i[1]),
        .set_fired    (pulse_done),
        .cause        (fail_cause_o),
        .cause_valid  (fail_valid_o),
        .fired        (wdt_fired_o)
    );

    assign sys_rst_o = pulse_active;
endmodule

// File: rtl/wdog_supervisor_chk.sv
// Module: property checker for the watchdog supervisor, attached by bind.
// Observes only the top-level ports. Assumes the same parameters as the
// instance it is bound to.
module wdog_supervisor_chk
    import wdog_pkg::*;
#(
    parameter int NUM_CKPT         = 4,
    parameter int RST_PULSE_CYCLES = 16
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 wr_en_i,
    input logic [1:0]           wr_addr_i,
    input logic [WR_DATA_W-1:0] wr_data_i,
    input logic                 dbg_halt_i,
    input logic                 sys_rst_o,
    input logic [NUM_CKPT-1:0]  ckpt_flags_o,
    input logic [NUM_CKPT-1:0]  req_mask_o,
    input logic [NUM_CKPT-1:0]  fail_cause_o,
    input logic                 fail_valid_o,
    input logic                 wdt_fired_o
);
    logic [31:0] hi_run;
    logic        kick_wr, clr_cause_wr, clr_fired_wr, kick_ok;

    // Run length of the reset pulse, counted in cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= '0;
        else if (sys_rst_o)
            hi_run <= hi_run + 1;
        else
            hi_run <= '0;
    end

    // Decode of software writes as seen at the ports.
    always_comb begin
        kick_wr      = wr_en_i && (wr_addr_i == REG_KICK);
        clr_cause_wr = wr_en_i && !sys_rst_o && (wr_addr_i == REG_CLEAR) && wr_data_i[0];
        clr_fired_wr = wr_en_i && !sys_rst_o && (wr_addr_i == REG_CLEAR) && wr_data_i[1];
        kick_ok      = (ckpt_flags_o & req_mask_o) == req_mask_o;
    end

    assert_flags_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!sys_rst_o && !kick_wr) |=> ((ckpt_flags_o & $past(ckpt_flags_o)) == $past(ckpt_flags_o)));

    assert_kick_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_wr && !dbg_halt_i && !sys_rst_o && kick_ok) |=> (ckpt_flags_o == '0 && !sys_rst_o));

    assert_kick_refuse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (kick_wr && !sys_rst_o && !kick_ok) |=> (ckpt_flags_o == $past(ckpt_flags_o)));

    assert_cause_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_valid_o && !clr_cause_wr) |=> (fail_valid_o && $stable(fail_cause_o)));

    assert_pulse_max_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |-> (hi_run < RST_PULSE_CYCLES));

    assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (hi_run == RST_PULSE_CYCLES));

    assert_pulse_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_rst_o) |-> (ckpt_flags_o == '0 && wdt_fired_o));

    assert_fired_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_fired_o && !clr_fired_wr) |=> wdt_fired_o);

    assert_no_reset_dbg_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_halt_i && !sys_rst_o) |=> !sys_rst_o);

    assert_mask_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_o |=> $stable(req_mask_o));
endmodule

bind wdog_supervisor wdog_supervisor_chk #(
    .NUM_CKPT         (NUM_CKPT),
    .RST_PULSE_CYCLES (RST_PULSE_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en_i      (wr_en_i),
    .wr_addr_i    (wr_addr_i),
    .wr_data_i    (wr_data_i),
    .dbg_halt_i   (dbg_halt_i),
    .sys_rst_o    (sys_rst_o),
    .ckpt_flags_o (ckpt_flags_o),
    .req_mask_o   (req_mask_o),
    .fail_cause_o (fail_cause_o),
    .fail_valid_o (fail_valid_o),
    .wdt_fired_o  (wdt_fired_o)
);

// File: tb/wdog_supervisor_tb_top.sv
`timescale 1ns/1ps
// Bench: exhaustive mask/flag sweep plus edge-counted timing tests of the
// watchdog supervisor in a small configuration.
module wdog_supervisor_tb_top;
    localparam int N = 3;
    localparam int T = 20;
    localparam int P = 4;
    localparam logic [1:0] A_CKPT = 2'd0, A_KICK = 2'd1, A_MASK = 2'd2, A_CLR = 2'd3;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [7:0]   wr_data = '0;
    logic         dbg = 1'b0;
    logic         sys_rst;
    logic [N-1:0] flags, mask, cause;
    logic         cvalid, fired;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wdog_supervisor #(
        .NUM_CKPT(N), .TIMEOUT_CYCLES(T), .RST_PULSE_CYCLES(P)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .dbg_halt_i(dbg), .sys_rst_o(sys_rst),
        .ckpt_flags_o(flags), .req_mask_o(mask), .fail_cause_o(cause),
        .fail_valid_o(cvalid), .wdt_fired_o(fired)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; dbg = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // One write; returns at the falling edge after the write edge.
    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1 rst", sys_rst, 0);
        chk("R1 flags", flags, 0);
        chk("R1 mask", mask, 3'b111);
        chk("R1 cause", {cvalid, cause}, 0);
        chk("R1 fired", fired, 0);
        rst_n = 1'b1;

        // R2: OR-in of checkpoint bits, upper data bits ignored
        wr(A_CKPT, 8'hF9);
        chk("R2 flags", flags, 3'b001);
        wr(A_CKPT, 8'h04);
        chk("R2 flags or", flags, 3'b101);

        // R3/R4/R5/R9: every mask against every flag pattern
        for (int m = 0; m < 8; m++) begin
            for (int f = 0; f < 8; f++) begin
                logic ok;
                logic [N-1:0] miss;
                do_reset();
                wr(A_MASK, 8'(m));
                wr(A_CKPT, 8'(f));
                wr(A_KICK, 8'hA5);
                miss = N'(m) & ~N'(f);
                ok   = (miss == '0);
                chk("R3 R4 R9 flags after kick", flags, ok ? 0 : f);
                chk("R5 valid", cvalid, !ok);
                chk("R5 cause", cause, ok ? 0 : miss);
            end
        end

        // R3, R6, R7, R10: accepted kick timing and pulse
        do_reset();
        wr(A_CKPT, 8'h07);
        wr(A_KICK, 8'h00);
        repeat (T - 1) @(negedge clk);
        chk("R3 no early reset", sys_rst, 0);
        @(negedge clk);
        chk("R3 reset at timeout", sys_rst, 1);
        wr(A_MASK, 8'h00);
        wr(A_CKPT, 8'h07);
        chk("R6 pulse cycle 3", sys_rst, 1);
        chk("R10 mask unchanged", mask, 3'b111);
        @(negedge clk);
        chk("R6 pulse cycle 4", sys_rst, 1);
        @(negedge clk);
        chk("R6 pulse ended", sys_rst, 0);
        chk("R7 flags cleared", flags, 0);
        chk("R7 fired set", fired, 1);
        chk("R10 mask still", mask, 3'b111);

        // R4, R5, R7: refused kick keeps schedule; cause handling
        do_reset();
        wr(A_CKPT, 8'h07);
        wr(A_KICK, 8'h00);
        wr(A_CKPT, 8'h01);
        wr(A_KICK, 8'h00);
        chk("R4 flags kept", flags, 3'b001);
        chk("R5 cause first", {cvalid, cause}, {1'b1, 3'b110});
        repeat (T - 3) @(negedge clk);
        chk("R4 no early reset", sys_rst, 0);
        @(negedge clk);
        chk("R4 reset on schedule", sys_rst, 1);
        repeat (P) @(negedge clk);
        chk("R6 pulse over", sys_rst, 0);
        chk("R7 cause survives", {cvalid, cause}, {1'b1, 3'b110});
        wr(A_CKPT, 8'h02);
        wr(A_KICK, 8'h00);
        chk("R5 second refusal ignored", cause, 3'b110);
        wr(A_CLR, 8'h01);
        chk("R5 cleared", {cvalid, cause}, 0);
        chk("R7 fired kept by bit0 clear", fired, 1);
        wr(A_KICK, 8'h00);
        chk("R5 recapture", {cvalid, cause}, {1'b1, 3'b101});
        wr(A_CLR, 8'h02);
        chk("R7 fired cleared", fired, 0);
        chk("R7 cause kept by bit1 clear", cause, 3'b101);

        // R8: debug halt
        do_reset();
        dbg = 1'b1;
        begin
            logic seen = 1'b0;
            for (int i = 0; i < 3 * T; i++) begin
                @(negedge clk);
                if (sys_rst) seen = 1'b1;
            end
            chk("R8 no reset in debug", seen, 0);
        end
        wr(A_CKPT, 8'h01);
        wr(A_KICK, 8'h00);
        chk("R8 refused kick ignored", cvalid, 0);
        wr(A_CKPT, 8'h06);
        wr(A_KICK, 8'h00);
        chk("R8 good kick ignored", flags, 3'b111);
        dbg = 1'b0;
        repeat (T - 1) @(negedge clk);
        chk("R8 full interval after release", sys_rst, 0);
        @(negedge clk);
        chk("R8 reset after release", sys_rst, 1);

        finish_run();
    end
endmodule